// File: doc/BRIEF.md
# Bus-Master DMA Channel Register File

This block is the register file for one channel of a bus-master DMA engine for a disk controller. The host programs three registers over a simple byte-lane register port: a command byte (run bit and transfer direction), a status byte (active, error and interrupt flags plus two plain capability bits) and a descriptor-table base address. The block turns command writes into one-cycle start and cancel pulses for the transfer engine. It keeps a table pointer for the engine, which the engine steps forward one descriptor at a time.

The drive's interrupt line is passed straight to the host. A rising edge on that line also latches the interrupt flag in status, and software clears the flag by writing a one to it. The engine reports the end of a transfer and any error through single-cycle inputs. A synchronous channel clear, and the asynchronous reset, return every register to zero. The channel clear also aborts a running transfer.

Top module: `bmdma_regs`

## Requirements
- R1: A command write (reg_sel=0) stores only bits 0 (run) and 3 (direction) of wdata[7:0]. Every other bit reads back zero, and xfer_dir follows the stored bit 3.
- R2: A command write whose bit 0 equals the stored run bit produces no eng_start or eng_cancel pulse and leaves the active flag and tbl_ptr unchanged. Only the stored command value changes.
- R3: A command write that changes the run bit from 1 to 0 produces a one-cycle eng_cancel pulse after the write edge and clears status bit 0 (active).
- R4: A command write that changes the run bit from 0 to 1 loads tbl_ptr from the base register. If status bit 0 is clear, it also sets that bit and produces a one-cycle eng_start pulse after the write edge. If the bit is already set, no pulse is produced.
- R5: A base write (reg_sel=2) with reg_size 0, 1 or 2 (1, 2 or 4 bytes) at byte offset reg_off changes only the addressed byte lanes, taking wdata[7:0] into the lane at reg_off and upward from there. Base bits [1:0] always hold zero.
- R6: A base read returns the base shifted down by 8*reg_off bits and masked to the access width. Command and status reads return the byte zero-extended.
- R7: host_irq equals drv_irq in the same cycle. A rising edge of drv_irq sets status bit 2 (interrupt). A held-high or low level sets nothing and clears nothing.
- R8: Reset, and a one-cycle chan_clr, clear command, status, base and tbl_ptr. chan_clr also produces an eng_cancel pulse if status bit 0 was set.
- R9: A status write (reg_sel=1) clears bit 1 (error) and bit 2 (interrupt) where wdata has a one and stores bits 6:5. It cannot change bit 0. eng_err sets bit 1, and a set in the same cycle wins over a clear.
- R10: eng_done makes status bit 0 equal to eng_more: the bit clears if no more data remains, and otherwise stays set.
- R11: Each eng_step cycle advances tbl_ptr by DESC_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_clr | input | 1 | Synchronous channel clear |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 status, 2 base |
| reg_off | input | 2 | Byte offset within the base register |
| reg_size | input | 2 | Access width: 0 one byte, 1 two bytes, 2 four bytes |
| wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| rdata | output | 32 | Read data for the selected register |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_cancel | output | 1 | One-cycle cancel pulse to the engine |
| xfer_dir | output | 1 | Transfer direction from command bit 3 |
| tbl_ptr | output | 32 | Current descriptor table pointer |
| eng_step | input | 1 | Engine advances to the next descriptor |
| eng_done | input | 1 | Engine finished a transfer |
| eng_more | input | 1 | Qualifies eng_done: more data remains |
| eng_err | input | 1 | Engine error event |
| drv_irq | input | 1 | Interrupt level from the drive |
| host_irq | output | 1 | Interrupt level to the host |

## Verification
The bench builds the block with its default parameters: a 32-bit address, so four byte lanes, and 8-byte descriptors. With these values every combination of offset and width in the byte-lane merge and the read extract is reachable, including an access that stops at the top lane. The bench drives the run bit through every transition: unchanged, rising while idle, rising while already active, and falling. It also drives the interrupt line through rising edges, held levels and falls, and checks that held levels never re-latch a flag software has cleared.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_BASE = 2'd2
    } reg_sel_e;

    localparam int CMD_RUN_BIT  = 0;
    localparam int CMD_DIR_BIT  = 3;
    localparam logic [7:0] CMD_KEEP_MASK = 8'h09;

    localparam int ST_ACT_BIT = 0;
    localparam int ST_ERR_BIT = 1;
    localparam int ST_INT_BIT = 2;
    localparam int ST_CAP_LO  = 5;
    localparam int ST_CAP_HI  = 6;
endpackage

// File: rtl/bmdma_lane_merge.sv
module bmdma_lane_merge #(
    parameter int ADDR_W = 32,
    localparam int LANES = ADDR_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [ADDR_W-1:0] cur_val,
    input  logic [ADDR_W-1:0] wr_val,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] merged,
    output logic [ADDR_W-1:0] extract
);
    logic [ADDR_W-1:0] shifted_wr;
    logic [ADDR_W-1:0] shifted_rd;
    int unsigned       nbytes;

    always_comb begin
        nbytes     = 32'd1 << size;
        shifted_wr = wr_val << {off, 3'b000};
        shifted_rd = cur_val >> {off, 3'b000};
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic hit_wr;
        logic keep_rd;
        always_comb begin
            hit_wr  = (k >= int'(off)) && (k < int'(off) + int'(nbytes));
            keep_rd = (k < int'(nbytes));
            merged[8*k +: 8]  = hit_wr ? shifted_wr[8*k +: 8] : cur_val[8*k +: 8];
            extract[8*k +: 8] = keep_rd ? shifted_rd[8*k +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/bmdma_irq_edge.sv
module bmdma_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_in;
        rise   = level_in & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 8,
    parameter int ALIGN_BITS = 2,
    localparam int LANES = ADDR_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_clr,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [1:0]        reg_size,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output logic              eng_start,
    output logic              eng_cancel,
    output logic              xfer_dir,
    output logic [ADDR_W-1:0] tbl_ptr,
    input  logic              eng_step,
    input  logic              eng_done,
    input  logic              eng_more,
    input  logic              eng_err,
    input  logic              drv_irq,
    output logic              host_irq
);
    import bmdma_pkg::*;

    localparam logic [ADDR_W-1:0] ALIGN_CLR = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

    typedef struct packed {
        logic [7:0]        cmd;
        logic [7:0]        stat;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] ptr;
        logic              start_p;
        logic              cancel_p;
    } regs_t;

    regs_t r_d, r_q;
    logic [ADDR_W-1:0] base_merged, base_extract;
    logic              irq_rise;
    logic              run_new;

    bmdma_lane_merge #(.ADDR_W(ADDR_W)) u_merge (
        .cur_val (r_q.base),
        .wr_val  (wdata),
        .off     (reg_off),
        .size    (reg_size),
        .merged  (base_merged),
        .extract (base_extract)
    );

    bmdma_irq_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (drv_irq),
        .rise     (irq_rise)
    );

    always_comb begin
        r_d          = r_q;
        r_d.start_p  = 1'b0;
        r_d.cancel_p = 1'b0;
        run_new      = wdata[CMD_RUN_BIT];

        if (eng_step) r_d.ptr = r_q.ptr + ADDR_W'(DESC_BYTES);
        if (eng_done) r_d.stat[ST_ACT_BIT] = eng_more;

        if (reg_wr) begin
            case (reg_sel)
                SEL_CMD: begin
                    if (run_new != r_q.cmd[CMD_RUN_BIT]) begin
                        if (!run_new) begin
                            r_d.cancel_p           = 1'b1;
                            r_d.stat[ST_ACT_BIT]   = 1'b0;
                        end else begin
                            r_d.ptr = r_q.base;
                            if (!r_q.stat[ST_ACT_BIT]) begin
                                r_d.stat[ST_ACT_BIT] = 1'b1;
                                r_d.start_p          = 1'b1;
                            end
                        end
                    end
                    r_d.cmd = wdata[7:0] & CMD_KEEP_MASK;
                end
                SEL_STAT: begin
                    if (wdata[ST_ERR_BIT]) r_d.stat[ST_ERR_BIT] = 1'b0;
                    if (wdata[ST_INT_BIT]) r_d.stat[ST_INT_BIT] = 1'b0;
                    r_d.stat[ST_CAP_HI:ST_CAP_LO] = wdata[ST_CAP_HI:ST_CAP_LO];
                end
                SEL_BASE: r_d.base = base_merged & ALIGN_CLR;
                default: ;
            endcase
        end

        if (eng_err)  r_d.stat[ST_ERR_BIT] = 1'b1;
        if (irq_rise) r_d.stat[ST_INT_BIT] = 1'b1;

        if (chan_clr) begin
            r_d          = '0;
            r_d.cancel_p = r_q.stat[ST_ACT_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_sel)
            SEL_CMD:  rdata = {{(ADDR_W-8){1'b0}}, r_q.cmd};
            SEL_STAT: rdata = {{(ADDR_W-8){1'b0}}, r_q.stat};
            SEL_BASE: rdata = base_extract;
            default:  rdata = '0;
        endcase
    end

    assign eng_start  = r_q.start_p;
    assign eng_cancel = r_q.cancel_p;
    assign xfer_dir   = r_q.cmd[CMD_DIR_BIT];
    assign tbl_ptr    = r_q.ptr;
    assign host_irq   = drv_irq;

    assert_cmd_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd & ~CMD_KEEP_MASK) == 8'h00);

    assert_same_run_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_sel == SEL_CMD && wdata[CMD_RUN_BIT] == r_q.cmd[CMD_RUN_BIT] && !chan_clr
        |=> !eng_start && !eng_cancel);

    assert_cancel_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cancel |-> !r_q.stat[ST_ACT_BIT]);

    assert_start_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> r_q.stat[ST_ACT_BIT] && tbl_ptr == r_q.base);

    assert_base_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.base[ALIGN_BITS-1:0] == '0);

    assert_irq_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rise && !chan_clr |=> r_q.stat[ST_INT_BIT]);

    assert_done_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && !eng_more && !chan_clr && !(reg_wr && reg_sel == SEL_CMD)
        |=> !r_q.stat[ST_ACT_BIT]);

    assert_done_more_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && eng_more && !chan_clr && !(reg_wr && reg_sel == SEL_CMD)
        |=> r_q.stat[ST_ACT_BIT]);
endmodule

// File: tb/bmdma_regs_tb.sv
`timescale 1ns/1ps
module bmdma_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_clr = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [1:0]  reg_off = 2'd0;
    logic [1:0]  reg_size = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        eng_start, eng_cancel, xfer_dir, host_irq;
    logic [31:0] tbl_ptr;
    logic        eng_step = 1'b0, eng_done = 1'b0, eng_more = 1'b0, eng_err = 1'b0;
    logic        drv_irq = 1'b0;

    int checks = 0;
    int failures = 0;
    int n_start = 0;
    int n_cancel = 0;
    logic rd_req = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_item_t;
    exp_item_t exp_q[$];

    always #2 clk = ~clk;

    bmdma_regs u_dut (
        .clk(clk), .rst_n(rst_n), .chan_clr(chan_clr), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_off(reg_off), .reg_size(reg_size), .wdata(wdata),
        .rdata(rdata), .eng_start(eng_start), .eng_cancel(eng_cancel),
        .xfer_dir(xfer_dir), .tbl_ptr(tbl_ptr), .eng_step(eng_step),
        .eng_done(eng_done), .eng_more(eng_more), .eng_err(eng_err),
        .drv_irq(drv_irq), .host_irq(host_irq)
    );

    // Monitor: pulse counters and scoreboard for register reads.
    always @(posedge clk) begin
        #1;
        if (eng_start)  n_start++;
        if (eng_cancel) n_cancel++;
        if (rd_req) begin
            exp_item_t it;
            it = exp_q.pop_front();
            checks++;
            if (rdata !== it.exp) begin
                failures++;
                $display("FAIL %s: rdata actual=%h expected=%h", it.tag, rdata, it.exp);
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [1:0] off,
                      input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_off = off; reg_size = sz; wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [1:0] off,
                      input logic [1:0] sz, input logic [31:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        reg_sel = sel; reg_off = off; reg_size = sz;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic done_ev(input logic more);
        @(negedge clk);
        eng_done = 1'b1; eng_more = more;
        @(negedge clk);
        eng_done = 1'b0; eng_more = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        rd(2'd0, 0, 0, 32'h0, "R8 reset cmd");
        rd(2'd1, 0, 0, 32'h0, "R8 reset status");
        rd(2'd2, 0, 2, 32'h0, "R8 reset base");
        chk(tbl_ptr, 32'h0, "R8 reset tbl_ptr");

        // R5/R6: base lanes
        wr(2'd2, 0, 2, 32'h1234_5677);
        rd(2'd2, 0, 2, 32'h1234_5674, "R5 full write low bits zero");
        rd(2'd2, 1, 0, 32'h0000_0056, "R6 byte read off1");
        rd(2'd2, 2, 1, 32'h0000_1234, "R6 half read off2");
        rd(2'd2, 3, 1, 32'h0000_0012, "R6 half read at top lane");
        wr(2'd2, 0, 0, 32'h0000_00FF);
        rd(2'd2, 0, 2, 32'h1234_56FC, "R5 byte write lane0");
        wr(2'd2, 2, 1, 32'h0000_ABCD);
        rd(2'd2, 0, 2, 32'hABCD_56FC, "R5 half write off2");
        wr(2'd2, 3, 0, 32'h0000_009A);
        rd(2'd2, 0, 2, 32'h9ACD_56FC, "R5 byte write off3");

        // R1/R4: start
        wr(2'd0, 0, 0, 32'h0000_00FF);
        chk(n_start, 1, "R4 start pulse");
        chk(tbl_ptr, 32'h9ACD_56FC, "R4 pointer reload");
        chk({31'b0, xfer_dir}, 1, "R1 direction bit");
        rd(2'd0, 0, 0, 32'h09, "R1 command mask");
        rd(2'd1, 0, 0, 32'h01, "R4 active set");

        // R11: pointer steps
        @(negedge clk); eng_step = 1'b1;
        @(negedge clk); @(negedge clk); eng_step = 1'b0;
        chk(tbl_ptr, 32'h9ACD_570C, "R11 two steps");

        // R2: same run bit
        wr(2'd0, 0, 0, 32'h01);
        chk(n_start, 1, "R2 no second start");
        chk(n_cancel, 0, "R2 no cancel");
        chk(tbl_ptr, 32'h9ACD_570C, "R2 pointer untouched");
        rd(2'd0, 0, 0, 32'h01, "R2 command value updated");

        // R10: done events
        done_ev(1'b1);
        rd(2'd1, 0, 0, 32'h01, "R10 more keeps active");
        done_ev(1'b0);
        rd(2'd1, 0, 0, 32'h00, "R10 last clears active");
        wr(2'd0, 0, 0, 32'h01);
        chk(n_start, 1, "R2 run held while idle");
        rd(2'd1, 0, 0, 32'h00, "R2 active stays clear");

        // R3: stop
        wr(2'd0, 0, 0, 32'h00);
        chk(n_cancel, 1, "R3 cancel pulse");
        wr(2'd0, 0, 0, 32'h01);
        chk(n_start, 2, "R4 restart");
        wr(2'd0, 0, 0, 32'h08);
        chk(n_cancel, 2, "R3 second cancel");
        rd(2'd1, 0, 0, 32'h00, "R3 active cleared");

        // R4: rising run while already active
        done_ev(1'b1);
        wr(2'd2, 0, 2, 32'h0000_1000);
        wr(2'd0, 0, 0, 32'h01);
        chk(n_start, 2, "R4 no start when active");
        chk(tbl_ptr, 32'h0000_1000, "R4 reload when active");
        rd(2'd1, 0, 0, 32'h01, "R4 active kept");
        wr(2'd0, 0, 0, 32'h00);
        chk(n_cancel, 3, "R3 cancel after active start");

        // R7: interrupt
        @(negedge clk); drv_irq = 1'b1;
        #1 chk({31'b0, host_irq}, 1, "R7 host follows high");
        rd(2'd1, 0, 0, 32'h04, "R7 rise latches");
        wr(2'd1, 0, 0, 32'h04);
        rd(2'd1, 0, 0, 32'h00, "R7 held level no relatch");
        @(negedge clk); drv_irq = 1'b0;
        #1 chk({31'b0, host_irq}, 0, "R7 host follows low");
        rd(2'd1, 0, 0, 32'h00, "R7 low leaves clear");
        @(negedge clk); drv_irq = 1'b1;
        @(negedge clk); drv_irq = 1'b0;
        rd(2'd1, 0, 0, 32'h04, "R7 low leaves set");

        // R9: status write rules
        wr(2'd1, 0, 0, 32'h65);
        rd(2'd1, 0, 0, 32'h60, "R9 w1c and cap bits, active ignored");
        @(negedge clk); eng_err = 1'b1;
        @(negedge clk); eng_err = 1'b0;
        rd(2'd1, 0, 0, 32'h62, "R9 error set");
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd1; reg_off = 0; reg_size = 0; wdata = 32'h02; eng_err = 1'b1;
        @(negedge clk); reg_wr = 1'b0; eng_err = 1'b0;
        rd(2'd1, 0, 0, 32'h02, "R9 set wins over clear");
        wr(2'd1, 0, 0, 32'h03);
        rd(2'd1, 0, 0, 32'h00, "R9 clear error");

        // R8: channel clear while active
        wr(2'd2, 0, 2, 32'h0000_2000);
        wr(2'd0, 0, 0, 32'h09);
        chk(n_start, 3, "R8 setup start");
        @(negedge clk); chan_clr = 1'b1;
        @(negedge clk); chan_clr = 1'b0;
        chk(n_cancel, 4, "R8 clear cancels");
        chk(tbl_ptr, 32'h0, "R8 clear pointer");
        rd(2'd0, 0, 0, 32'h0, "R8 clear cmd");
        rd(2'd1, 0, 0, 32'h0, "R8 clear status");
        rd(2'd2, 0, 2, 32'h0, "R8 clear base");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        finish_run();
    end
endmodule